// File: doc/BRIEF.md
# Asynchronous SRAM Sequencer

This block sits between a clocked host and an external asynchronous static RAM with 131072 byte-wide words. The host offers one request at a time on a valid/ready port: a write-enable flag, a 17-bit word address and, for writes, one data byte. The block accepts the request and then plays out the strobe sequence that the RAM needs. Read results come back on a separate port as a byte with a one-cycle valid pulse.

On the memory side the block drives the address and two chip selects of opposite polarity. The low-active select and the high-active select are always asserted together. It also drives a low-active write strobe, a low-active output enable, and a data byte with its own driver-enable. The RAM is selected only for the length of one operation.

Every wait is a whole number of clock cycles, worked out at elaboration from the clock period and the RAM's speed-grade minimums. Each minimum is divided by the period and rounded up. Before the block drives the shared data lines it waits out the RAM's worst-case output-release time. It ends a write by raising the write strobe while both selects stay active, so the commit edge is always the write strobe's rising edge.

Top module: `asram_ctl`

## Requirements
- R1: During and right after reset: req_ready=1, mem_cs_lo_n=1, mem_cs_hi=0, mem_wr_n=1, mem_rd_n=1, mem_dq_drive=0 and rsp_valid=0.
- R2: The RAM is selected (mem_cs_lo_n=0 and mem_cs_hi=1) in every cycle from the clock edge that accepts a request until the operation completes. It is deselected (mem_cs_lo_n=1, mem_cs_hi=0) in every cycle where req_ready=1.
- R3: While the RAM is selected, mem_addr equals the accepted request address and does not change.
- R4: mem_wr_n goes low only while the RAM is selected. It stays low for PULSE cycles, which is 14 with the defaults. It rises while both selects are still active. The write byte is driven for at least the data setup minimum (30 ns) before that rising edge.
- R5: mem_dq_drive is 1 only while mem_rd_n=1. It is asserted no earlier than the output-release minimum (25 ns) after mem_rd_n last rose. It drops in the cycle after mem_wr_n returns high.
- R6: For a read, mem_rd_n is low for RDC cycles, which is 18 with the defaults. mem_dq_in is sampled at the end of the last of those cycles. That byte then appears on rsp_data with rsp_valid=1 for exactly one cycle, in the cycle after the sample.
- R7: req_ready drops in the cycle after a request is accepted. It stays low for RDC cycles for a read, and for TURN+PULSE+1 cycles for a write, which is 7+14+1=22 with the defaults.
- R8: Cycle counts are ceil(minimum_ns / CLK_PERIOD_NS), with at least 1. RDC is the largest of the address access, output-enable access and cycle minimums. PULSE is the largest of the write-pulse and data-setup minimums. PULSE is raised further if TURN+PULSE+1 would otherwise be shorter than the cycle minimum.
- R9: A read returns the byte written last to the same address. This includes a read right after a write, a write right after a read, and the address 0 and 0x1FFFF bounds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Host offers a request |
| req_ready | output | 1 | Block can accept a request |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | 17 | Word address |
| req_wdata | input | 8 | Byte to write |
| rsp_valid | output | 1 | One-cycle read result strobe |
| rsp_data | output | 8 | Read result |
| mem_addr | output | 17 | RAM address |
| mem_cs_lo_n | output | 1 | RAM select, active low |
| mem_cs_hi | output | 1 | RAM select, active high |
| mem_wr_n | output | 1 | RAM write strobe, active low |
| mem_rd_n | output | 1 | RAM output enable, active low |
| mem_dq_out | output | 8 | Byte driven toward the RAM |
| mem_dq_drive | output | 1 | Enables the block's data driver |
| mem_dq_in | input | 8 | Byte coming from the RAM |

## Verification
A corrupted sequencer state or wait counter shows up within one operation as a wrong busy length on req_ready, or as a strobe window that is too short or too long. Both are visible on the first request after the fault. If the turnaround count is wrong, the driver-enable comes up while the RAM may still be driving. The bench's RAM model reports this at the rising edge of the driver-enable. A short write pulse or missing setup is caught at the commit edge. A read sampled too early returns the model's filler byte instead of the stored one, and the scoreboard flags it on the rsp_valid pulse that cycle.

// File: rtl/asram_pkg.sv
package asram_pkg;

  typedef enum logic [2:0] {
    SQ_IDLE   = 3'd0,
    SQ_READ   = 3'd1,
    SQ_TURN   = 3'd2,
    SQ_WPULSE = 3'd3,
    SQ_WEND   = 3'd4
  } seq_state_t;

  // round a nanosecond minimum up to whole clock periods
  function automatic int unsigned ns_to_cyc(int unsigned ns, int unsigned period);
    return (ns + period - 1) / period;
  endfunction

  function automatic int unsigned umax(int unsigned a, int unsigned b);
    return (a > b) ? a : b;
  endfunction

  function automatic int unsigned read_cycles(int unsigned acc, int unsigned oe_acc,
                                              int unsigned cyc, int unsigned p);
    return umax(1, umax(ns_to_cyc(cyc, p), umax(ns_to_cyc(acc, p), ns_to_cyc(oe_acc, p))));
  endfunction

  function automatic int unsigned turn_cycles(int unsigned off, int unsigned p);
    return umax(1, ns_to_cyc(off, p));
  endfunction

  // write pulse must cover the strobe width, data setup and the remaining cycle time
  function automatic int unsigned pulse_cycles(int unsigned wp, int unsigned dsu,
                                               int unsigned cyc, int unsigned turn,
                                               int unsigned p);
    int unsigned base;
    int unsigned rest;
    base = umax(1, umax(ns_to_cyc(wp, p), ns_to_cyc(dsu, p)));
    rest = (ns_to_cyc(cyc, p) > turn + 1) ? ns_to_cyc(cyc, p) - turn - 1 : 0;
    return umax(base, rest);
  endfunction

endpackage

// File: rtl/asram_wait_ctr.sv
module asram_wait_ctr #(
  parameter int unsigned CW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  output logic          done
);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           cnt_q <= '0;
    else if (load)        cnt_q <= load_val;
    else if (cnt_q != '0) cnt_q <= cnt_q - 1'b1;
  end

  assign done = (cnt_q == '0);

  // the count only moves down unless reloaded
  assert_ctr_down_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));
endmodule

// File: rtl/asram_seq_fsm.sv
module asram_seq_fsm
  import asram_pkg::*;
#(
  parameter int unsigned CW        = 5,
  parameter int unsigned RD_CYC    = 18,
  parameter int unsigned TURN_CYC  = 7,
  parameter int unsigned PULSE_CYC = 14
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          start_we,
  input  logic          wait_done,
  output seq_state_t    state,
  output logic          ld,
  output logic [CW-1:0] ld_val
);
  seq_state_t nxt;

  always_comb begin
    nxt    = state;
    ld     = 1'b0;
    ld_val = '0;
    unique case (state)
      SQ_IDLE: if (start) begin
        ld = 1'b1;
        if (start_we) begin
          nxt    = SQ_TURN;
          ld_val = CW'(TURN_CYC - 1);
        end else begin
          nxt    = SQ_READ;
          ld_val = CW'(RD_CYC - 1);
        end
      end
      SQ_READ:   if (wait_done) nxt = SQ_IDLE;
      SQ_TURN:   if (wait_done) begin
        nxt    = SQ_WPULSE;
        ld     = 1'b1;
        ld_val = CW'(PULSE_CYC - 1);
      end
      SQ_WPULSE: if (wait_done) nxt = SQ_WEND;
      SQ_WEND:   nxt = SQ_IDLE;
      default:   nxt = SQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= SQ_IDLE;
    else        state <= nxt;
  end

  // a write always ends through the recovery cycle
  assert_wend_follows_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (state == SQ_WEND) |=> (state == SQ_IDLE));
endmodule

// File: rtl/asram_ctl.sv
module asram_ctl #(
  parameter int unsigned AW            = 17,
  parameter int unsigned DW            = 8,
  parameter int unsigned CLK_PERIOD_NS = 4,
  parameter int unsigned T_ACC_NS      = 70,
  parameter int unsigned T_OE_ACC_NS   = 35,
  parameter int unsigned T_CYCLE_NS    = 70,
  parameter int unsigned T_WP_NS       = 55,
  parameter int unsigned T_DSU_NS      = 30,
  parameter int unsigned T_OE_OFF_NS   = 25
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic          req_we,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  output logic          rsp_valid,
  output logic [DW-1:0] rsp_data,
  output logic [AW-1:0] mem_addr,
  output logic          mem_cs_lo_n,
  output logic          mem_cs_hi,
  output logic          mem_wr_n,
  output logic          mem_rd_n,
  output logic [DW-1:0] mem_dq_out,
  output logic          mem_dq_drive,
  input  logic [DW-1:0] mem_dq_in
);
  import asram_pkg::*;

  localparam int unsigned RD_CYC    = read_cycles(T_ACC_NS, T_OE_ACC_NS, T_CYCLE_NS, CLK_PERIOD_NS);
  localparam int unsigned TURN_CYC  = turn_cycles(T_OE_OFF_NS, CLK_PERIOD_NS);
  localparam int unsigned PULSE_CYC = pulse_cycles(T_WP_NS, T_DSU_NS, T_CYCLE_NS, TURN_CYC, CLK_PERIOD_NS);
  localparam int unsigned MAX_CYC   = umax(RD_CYC, umax(TURN_CYC, PULSE_CYC));
  localparam int unsigned CW        = $clog2(MAX_CYC + 1);
  localparam int unsigned RW        = CW + 2;

  seq_state_t    state;
  logic          ld;
  logic [CW-1:0] ld_val;
  logic          wait_done;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] wdata_q;
  logic [DW-1:0] rdata_q;
  logic          rvalid_q;

  // named internal events
  wire accept     = req_valid && req_ready;
  wire selected   = (state != SQ_IDLE);
  wire rd_capture = (state == SQ_READ) && wait_done;

  asram_seq_fsm #(
    .CW(CW), .RD_CYC(RD_CYC), .TURN_CYC(TURN_CYC), .PULSE_CYC(PULSE_CYC)
  ) u_fsm (
    .clk(clk), .rst_n(rst_n), .start(accept), .start_we(req_we),
    .wait_done(wait_done), .state(state), .ld(ld), .ld_val(ld_val)
  );

  asram_wait_ctr #(.CW(CW)) u_ctr (
    .clk(clk), .rst_n(rst_n), .load(ld), .load_val(ld_val), .done(wait_done)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q   <= '0;
      wdata_q  <= '0;
      rdata_q  <= '0;
      rvalid_q <= 1'b0;
    end else begin
      rvalid_q <= rd_capture;
      if (accept) begin
        addr_q  <= req_addr;
        wdata_q <= req_wdata;
      end
      if (rd_capture) rdata_q <= mem_dq_in;
    end
  end

  assign req_ready    = (state == SQ_IDLE);
  assign rsp_valid    = rvalid_q;
  assign rsp_data     = rdata_q;
  assign mem_addr     = addr_q;
  assign mem_cs_lo_n  = !selected;
  assign mem_cs_hi    = selected;
  assign mem_rd_n     = (state != SQ_READ);
  assign mem_wr_n     = (state != SQ_WPULSE);
  assign mem_dq_out   = wdata_q;
  assign mem_dq_drive = (state == SQ_WPULSE) || (state == SQ_WEND);

  // run-length counters used only by the assertions below
  logic [RW-1:0] oe_hi_run, we_lo_run;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      oe_hi_run <= '0;
      we_lo_run <= '0;
    end else begin
      oe_hi_run <= !mem_rd_n ? '0 : ((oe_hi_run == '1) ? oe_hi_run : oe_hi_run + 1'b1);
      we_lo_run <=  mem_wr_n ? '0 : ((we_lo_run == '1) ? we_lo_run : we_lo_run + 1'b1);
    end
  end

  assert_wr_selected_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_wr_n |-> (!mem_cs_lo_n && mem_cs_hi));
  assert_wr_end_selected_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_wr_n) |-> (!mem_cs_lo_n && mem_cs_hi));
  assert_pulse_len_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_wr_n) |-> (we_lo_run >= RW'(PULSE_CYC)));
  assert_drive_oe_high_R5: assert property (@(posedge clk) disable iff (!rst_n)
    mem_dq_drive |-> mem_rd_n);
  assert_turnaround_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_dq_drive) |-> (oe_hi_run >= RW'(TURN_CYC)));
  assert_release_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mem_dq_drive) |-> ($past(mem_wr_n) && mem_wr_n));
  assert_addr_stable_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_cs_lo_n && $past(!mem_cs_lo_n)) |-> $stable(mem_addr));
  assert_rsp_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);
  assert_busy_after_accept_R7: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> !req_ready);
endmodule

// File: tb/sim_asram_ctl.sv
module sim_asram_ctl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_we = 1'b0;
  logic [16:0] req_addr = '0;
  logic [7:0]  req_wdata = '0;
  logic        req_ready, rsp_valid;
  logic [7:0]  rsp_data;
  logic [16:0] mem_addr;
  logic        mem_cs_lo_n, mem_cs_hi, mem_wr_n, mem_rd_n, mem_dq_drive;
  logic [7:0]  mem_dq_out;
  logic [7:0]  mem_dq_in = 8'hEE;

  int checks = 0;
  int fails  = 0;
  bit finished = 0;

  always #2 clk = ~clk;  // 250 MHz

  asram_ctl u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_we(req_we), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data), .mem_addr(mem_addr),
    .mem_cs_lo_n(mem_cs_lo_n), .mem_cs_hi(mem_cs_hi), .mem_wr_n(mem_wr_n),
    .mem_rd_n(mem_rd_n), .mem_dq_out(mem_dq_out), .mem_dq_drive(mem_dq_drive),
    .mem_dq_in(mem_dq_in)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%0d exp=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // ---------------- behavioural RAM model ----------------
  logic [7:0] ram [logic [16:0]];
  logic [7:0] refm [logic [16:0]];
  time t_dq = 0, t_oe_rise = 0, t_rd = 0;
  wire sel_m  = !mem_cs_lo_n && mem_cs_hi;
  wire wr_act = sel_m && !mem_wr_n;
  wire rd_act = sel_m && !mem_rd_n && mem_wr_n;

  always @(mem_dq_out) t_dq = $time;
  always @(posedge mem_rd_n) t_oe_rise = $time;
  always @(posedge rd_act or mem_addr) t_rd = $time;
  always @(posedge mem_dq_drive) begin
    t_dq = $time;
    if (rst_n === 1'b1) chk(($time - t_oe_rise) >= 25, "R5 turnaround", $time - t_oe_rise, 25);
  end
  always @(negedge wr_act) begin
    if (rst_n === 1'b1) begin
      chk(mem_dq_drive === 1'b1, "R5 driven at commit", mem_dq_drive, 1);
      chk(($time - t_dq) >= 30, "R4 data setup", $time - t_dq, 30);
      ram[mem_addr] = mem_dq_out;
    end
  end
  always @(negedge clk) begin
    if (rst_n === 1'b1) begin
      if (!mem_wr_n && !sel_m) chk(0, "R4 strobe outside select", 0, 1);
      if (mem_dq_drive && !mem_rd_n) chk(0, "R5 contention", 0, 1);
    end
    if (rd_act && ($time - t_rd) >= 70)
      mem_dq_in <= ram.exists(mem_addr) ? ram[mem_addr] : 8'h00;
    else
      mem_dq_in <= 8'hEE;
  end

  // ---------------- scoreboard ----------------
  logic [7:0] expq [$];
  int  rsp_seen = 0;
  bit  prev_rv = 0;
  always @(negedge clk) begin
    if (rst_n === 1'b1) begin
      if (prev_rv && rsp_valid) chk(0, "R6 rsp pulse width", 2, 1);
      if (rsp_valid) begin
        rsp_seen++;
        if (expq.size() == 0) chk(0, "R6 unexpected rsp", rsp_data, -1);
        else begin
          logic [7:0] e;
          e = expq.pop_front();
          chk(rsp_data === e, "R9 read data", rsp_data, e);
        end
      end
      prev_rv = rsp_valid;
    end
  end

  task automatic do_op(input bit we, input logic [16:0] a, input logic [7:0] d);
    int busy = 0, oelow = 0, welow = 0, bad_sel = 0;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    if (!we) expq.push_back(refm.exists(a) ? refm[a] : 8'h00);
    else     refm[a] = d;
    req_valid = 1'b1; req_we = we; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0;
    while (!req_ready && busy < 1000) begin
      busy++;
      if (mem_cs_lo_n || !mem_cs_hi || mem_addr !== a) bad_sel++;
      if (!mem_rd_n) oelow++;
      if (!mem_wr_n) welow++;
      @(negedge clk);
    end
    chk(bad_sel == 0, "R2/R3 select and address held", bad_sel, 0);
    if (we) begin
      chk(busy == 22, "R7 write busy", busy, 22);
      chk(welow == 14, "R4 R8 write pulse cycles", welow, 14);
      chk(oelow == 0, "R5 no output enable in write", oelow, 0);
    end else begin
      chk(busy == 18, "R7 read busy", busy, 18);
      chk(oelow == 18, "R6 R8 output enable cycles", oelow, 18);
    end
    chk(mem_cs_lo_n && !mem_cs_hi && mem_wr_n && mem_rd_n && !mem_dq_drive,
        "R2 deselected when ready", {mem_cs_lo_n, mem_cs_hi, mem_wr_n, mem_rd_n, mem_dq_drive}, 5'b10110);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  initial begin
    int nreads = 0;
    repeat (3) @(negedge clk);
    chk(req_ready && mem_cs_lo_n && !mem_cs_hi && mem_wr_n && mem_rd_n && !mem_dq_drive && !rsp_valid,
        "R1 reset state", {req_ready, mem_cs_lo_n, mem_cs_hi, mem_wr_n, mem_rd_n, mem_dq_drive, rsp_valid}, 7'b1101100);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready && mem_cs_lo_n && !mem_cs_hi && !rsp_valid, "R1 after reset", req_ready, 1);
    // bounds and patterns
    do_op(1, 17'h00000, 8'h5A);
    do_op(1, 17'h1FFFF, 8'hA5);
    do_op(0, 17'h00000, 8'h00); nreads++;
    do_op(0, 17'h1FFFF, 8'h00); nreads++;
    do_op(0, 17'h01234, 8'h00); nreads++;  // never written
    for (int i = 0; i < 8; i++) do_op(1, 17'(17'h100 + i), 8'(1 << i));
    for (int i = 0; i < 8; i++) begin do_op(0, 17'(17'h100 + i), 8'h00); nreads++; end
    // read directly followed by write: turnaround path
    for (int i = 0; i < 6; i++) begin
      do_op(0, 17'(17'h100 + i), 8'h00); nreads++;
      do_op(1, 17'(17'h100 + i), 8'(8'hC0 ^ i));
    end
    // overwrite then read back
    do_op(1, 17'h0AAAA, 8'h55);
    do_op(1, 17'h0AAAA, 8'hAA);
    do_op(0, 17'h0AAAA, 8'h00); nreads++;
    for (int i = 0; i < 6; i++) begin do_op(0, 17'(17'h100 + i), 8'h00); nreads++; end
    repeat (4) @(negedge clk);
    chk(rsp_seen == nreads, "R6 one response per read", rsp_seen, nreads);
    chk(expq.size() == 0, "R9 all responses arrived", expq.size(), 0);
    finish_run();
  end

  initial begin
    repeat (50000) @(posedge clk);
    chk(0, "watchdog", 0, 1);
    finish_run();
  end
endmodule